// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the three slot registers of a downstream port that supports hot-plug: a read-only slot capability word, a slot control half-word and a slot status half-word. Software reaches them through a small dword-wide register port with byte enables. The capability word sits at dword 0. Dword 1 carries slot control in bits 15:0 and slot status in bits 31:16. The slot side delivers single-cycle pulses for attention button, hot-add, hot-remove and device-present-at-boot.

Every write that touches either slot control byte counts as one command. That command completes in the same cycle and sets the command-completed status bit. Writing 1 to the lock-command bit flips the lock status. From control and status the block forms a notification condition. With message signalling on, each change of that condition raises a one-cycle message pulse carrying the configured vector. With message signalling off, a level interrupt follows the condition. While the slot is locked, hot-add and hot-remove requests are refused and a busy flag is raised.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, slot control reads 0x03C0 (both indicator fields at the 'off' code 2'b11, every enable 0), slot status reads 0x0000, and `irq_level` and `msg_pulse` are 0.
- R2: A write to dword 1 with `wr_be[0]` or `wr_be[1]` set sets status bit 4 (command completed). A write to dword 1 that enables only bytes 2 and 3 does not set it.
- R3: Only control bits 0 (button enable), 3 (presence-change enable), 4 (command enable), 5 (hot-plug interrupt enable), 7:6 (attention indicator) and 9:8 (power indicator) are writable. All other control bits, including the lock-command bit 11, read as 0.
- R4: A write with `wr_be[1]` set and data bit 11 = 1 inverts status bit 7 (lock status).
- R5: Status bits 0, 3 and 4 clear when 1 is written to them (data bits 16, 19 and 20 with their byte enabled). Writing 1 to status bit 6 (presence state) or bit 7 (lock) has no effect.
- R6: A hot-add pulse sets status bit 6 and bit 3 (presence changed). A hot-remove pulse clears bit 6 and sets bit 3. A boot-present pulse sets bit 6 without touching bit 3.
- R7: While status bit 7 is 1, `plug_busy` equals the OR of the hot-add and hot-remove inputs, and such a request leaves status unchanged.
- R8: An attention-button pulse sets status bit 0.
- R9: The notification condition is control bit 5 AND any of status bits 0, 3 and 4 whose matching control enable bit is also 1.
- R10: With `msi_en` = 1, `msg_pulse` is high for exactly one cycle after each change of the condition and `msg_vector` equals `msg_num`. Setting a status bit that is already set raises no pulse.
- R11: With `msi_en` = 0, `irq_level` equals the condition. With `msi_en` = 1, `irq_level` is 0.
- R12: When an event pulse and a write-one-to-clear of the same status bit occur in the same cycle, the bit ends up set.
- R13: Dword 0 reads {SLOT_NUM in bits 31:19, flag bits 0, 3, 4, 5, 6 and 17 set}, regardless of any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write dword select (0 capability, 1 control/status) |
| wr_be | input | 4 | Write byte enables |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read dword select |
| rd_data | output | 32 | Read data for `rd_sel` |
| evt_button | input | 1 | Attention button pulse |
| evt_hot_add | input | 1 | Hot-add request pulse |
| evt_hot_remove | input | 1 | Hot-remove request pulse |
| evt_boot_present | input | 1 | Device present at power-up pulse |
| plug_busy | output | 1 | Hot-plug request refused, slot locked |
| msi_en | input | 1 | Message signalling enable |
| msg_num | input | VEC_W | Interrupt message number |
| irq_level | output | 1 | Level interrupt |
| msg_pulse | output | 1 | One-cycle message request |
| msg_vector | output | VEC_W | Vector sent with the message |

## Verification
The properties assume that hot-add and hot-remove are never pulsed in the same cycle and that boot-present does not coincide with either. Each event input is also taken to be a pulse rather than a held level. The stimulus raises at most one slot event per cycle and drops every event and write strobe one cycle after raising it. The one exception is the deliberate clash between an event and a clear of the same status bit. A lock toggle together with a request in the same cycle is not exercised, so the property on refused requests reads the lock state from before the edge.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

    localparam int REG_W = 16;
    localparam int DW_W  = 2 * REG_W;
    localparam int BE_W  = DW_W / 8;

    // slot control bit positions
    localparam int CTL_BTN_EN   = 0;
    localparam int CTL_PDC_EN   = 3;
    localparam int CTL_CC_EN    = 4;
    localparam int CTL_HPI_EN   = 5;
    localparam int CTL_LOCK_CMD = 11;

    // slot status bit positions
    localparam int STS_BTN  = 0;
    localparam int STS_PDC  = 3;
    localparam int STS_CC   = 4;
    localparam int STS_PRES = 6;
    localparam int STS_LOCK = 7;

    localparam logic [REG_W-1:0] CTL_WMASK = 16'h03F9;
    localparam logic [REG_W-1:0] EVT_MASK  = 16'h0019;
    localparam logic [REG_W-1:0] CTL_RESET = 16'h03C0;

    typedef struct packed {
        logic            en;
        logic            sel;
        logic [BE_W-1:0] be;
        logic [DW_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic btn;
        logic add;
        logic rem;
        logic boot;
    } slot_evt_t;

    function automatic logic [REG_W-1:0] byte_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic notify_cond(input logic [REG_W-1:0] ctl,
                                         input logic [REG_W-1:0] sts);
        return ctl[CTL_HPI_EN] && (|(ctl & sts & EVT_MASK));
    endfunction

endpackage

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          req,
    input  slot_evt_t        evt,
    output logic [REG_W-1:0] ctl_q,
    output logic [REG_W-1:0] sts_q
);
    logic [REG_W-1:0] ctl_d, sts_d, ctl_bm, sts_bm;
    logic hit_ctl, hit_sts, locked;

    always_comb begin
        hit_ctl = req.en && req.sel && (|req.be[1:0]);
        hit_sts = req.en && req.sel && (|req.be[3:2]);
        locked  = sts_q[STS_LOCK];
        ctl_bm  = byte_mask(req.be[1:0]) & CTL_WMASK;
        sts_bm  = byte_mask(req.be[3:2]) & EVT_MASK;
        ctl_d   = ctl_q;
        sts_d   = sts_q;

        // command: one write to control, whatever fields it touches
        if (hit_ctl) begin
            ctl_d = (ctl_q & ~ctl_bm) | (req.data[REG_W-1:0] & ctl_bm);
            if (req.be[1] && req.data[CTL_LOCK_CMD])
                sts_d[STS_LOCK] = ~locked;
        end

        // write-one-to-clear on event bits only
        if (hit_sts)
            sts_d = sts_d & ~(req.data[DW_W-1:REG_W] & sts_bm);

        // events applied last so they win over a same-cycle clear
        if (hit_ctl)  sts_d[STS_CC]  = 1'b1;
        if (evt.btn)  sts_d[STS_BTN] = 1'b1;
        if (evt.add && !locked) begin
            sts_d[STS_PRES] = 1'b1;
            sts_d[STS_PDC]  = 1'b1;
        end
        if (evt.rem && !locked) begin
            sts_d[STS_PRES] = 1'b0;
            sts_d[STS_PDC]  = 1'b1;
        end
        if (evt.boot) sts_d[STS_PRES] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
            sts_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            sts_q <= sts_d;
        end
    end
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
    import hp_slot_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] ctl,
    input  logic [REG_W-1:0] sts,
    input  logic             msi_en,
    input  logic [VEC_W-1:0] vec_in,
    output logic             irq_level,
    output logic             msg_pulse,
    output logic [VEC_W-1:0] msg_vector
);
    logic cond_now, cond_q;

    assign cond_now   = notify_cond(ctl, sts);
    assign irq_level  = !msi_en && cond_now;
    assign msg_pulse  = msi_en && (cond_now != cond_q);
    assign msg_vector = vec_in;

    always_ff @(posedge clk) begin
        if (rst) cond_q <= 1'b0;
        else     cond_q <= cond_now;
    end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int                  SLOT_NUM_W = 13,
    parameter logic [SLOT_NUM_W-1:0] SLOT_NUM = 13'd5,
    parameter int                  VEC_W      = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [3:0]       wr_be,
    input  logic [31:0]      wr_data,
    input  logic             rd_sel,
    output logic [31:0]      rd_data,
    input  logic             evt_button,
    input  logic             evt_hot_add,
    input  logic             evt_hot_remove,
    input  logic             evt_boot_present,
    output logic             plug_busy,
    input  logic             msi_en,
    input  logic [VEC_W-1:0] msg_num,
    output logic             irq_level,
    output logic             msg_pulse,
    output logic [VEC_W-1:0] msg_vector
);
    localparam int FLAG_W = DW_W - SLOT_NUM_W;
    localparam logic [FLAG_W-1:0] CAP_FLAGS =
        FLAG_W'((1 << 0) | (1 << 3) | (1 << 4) | (1 << 5) | (1 << 6) | (1 << 17));
    localparam logic [DW_W-1:0] CAP_WORD = {SLOT_NUM, CAP_FLAGS};

    wr_req_t          req;
    slot_evt_t        evt;
    logic [REG_W-1:0] ctl_q, sts_q;

    assign req = '{en: wr_en, sel: wr_sel, be: wr_be, data: wr_data};
    assign evt = '{btn: evt_button, add: evt_hot_add,
                   rem: evt_hot_remove, boot: evt_boot_present};

    hp_slot_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .evt   (evt),
        .ctl_q (ctl_q),
        .sts_q (sts_q)
    );

    hp_slot_notify #(.VEC_W(VEC_W)) u_notify (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl_q),
        .sts        (sts_q),
        .msi_en     (msi_en),
        .vec_in     (msg_num),
        .irq_level  (irq_level),
        .msg_pulse  (msg_pulse),
        .msg_vector (msg_vector)
    );

    assign plug_busy = sts_q[STS_LOCK] && (evt_hot_add || evt_hot_remove);
    assign rd_data   = rd_sel ? {sts_q, ctl_q} : CAP_WORD;
endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [3:0]  wr_be,
    input logic [31:0] wr_data,
    input logic        evt_button,
    input logic        evt_hot_add,
    input logic        msi_en,
    input logic        irq_level,
    input logic        msg_pulse,
    input logic [15:0] ctl_q,
    input logic [15:0] sts_q
);
    p_cmd_done_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && (|wr_be[1:0])) |=> sts_q[4]);

    p_ctl_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_q & ~16'h03F9) == 16'h0000);

    p_lock_flip_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && wr_be[1] && wr_data[11]) |=> (sts_q[7] != $past(sts_q[7])));

    p_hot_add_r6: assert property (@(posedge clk) disable iff (rst)
        (evt_hot_add && !sts_q[7]) |=> (sts_q[6] && sts_q[3]));

    p_refused_r7: assert property (@(posedge clk) disable iff (rst)
        (evt_hot_add && sts_q[7]) |=> $stable(sts_q[6]));

    p_button_r8: assert property (@(posedge clk) disable iff (rst)
        evt_button |=> sts_q[0]);

    p_pulse_msi_r10: assert property (@(posedge clk) disable iff (rst)
        msg_pulse |-> msi_en);

    p_level_off_r11: assert property (@(posedge clk) disable iff (rst)
        msi_en |-> !irq_level);
endmodule

bind hp_slot_ctrl hp_slot_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_be       (wr_be),
    .wr_data     (wr_data),
    .evt_button  (evt_button),
    .evt_hot_add (evt_hot_add),
    .msi_en      (msi_en),
    .irq_level   (irq_level),
    .msg_pulse   (msg_pulse),
    .ctl_q       (ctl_q),
    .sts_q       (sts_q)
);

// File: tb/tb_hp_slot_ctrl.sv
module tb_hp_slot_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] CAP_EXP = (32'd5 << 19) | 32'h0002_0079;

    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0, wr_sel = 0;
    logic [3:0]  wr_be = 0;
    logic [31:0] wr_data = 0;
    logic        rd_sel = 1;
    logic [31:0] rd_data;
    logic        evt_button = 0, evt_hot_add = 0, evt_hot_remove = 0, evt_boot_present = 0;
    logic        plug_busy;
    logic        msi_en = 0;
    logic [4:0]  msg_num = 0;
    logic        irq_level, msg_pulse;
    logic [4:0]  msg_vector;

    int n_tests = 0;
    int n_fail  = 0;

    hp_slot_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .evt_button(evt_button), .evt_hot_add(evt_hot_add),
        .evt_hot_remove(evt_hot_remove), .evt_boot_present(evt_boot_present),
        .plug_busy(plug_busy), .msi_en(msi_en), .msg_num(msg_num),
        .irq_level(irq_level), .msg_pulse(msg_pulse), .msg_vector(msg_vector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_ctl, m_sts;
    logic        m_prevc;
    bit          m_valid = 0;

    function automatic logic m_cond(input logic [15:0] c, input logic [15:0] s);
        return c[5] && ((c & s & 16'h0019) != 16'h0000);
    endfunction

    always @(posedge clk) begin
        logic [15:0] ns;
        logic        was_locked;
        if (rst) begin
            m_ctl   = 16'h03C0;
            m_sts   = 16'h0000;
            m_prevc = 1'b0;
        end else begin
            m_prevc    = m_cond(m_ctl, m_sts);
            was_locked = m_sts[7];
            ns         = m_sts;
            if (wr_en && wr_sel && wr_be[2])
                ns[7:0] = ns[7:0] & ~(wr_data[23:16] & 8'h19);
            if (wr_en && wr_sel && (wr_be[0] || wr_be[1])) begin
                if (wr_be[0]) m_ctl[7:0] = wr_data[7:0] & 8'hF9;
                if (wr_be[1]) begin
                    m_ctl[15:8] = wr_data[15:8] & 8'h03;
                    if (wr_data[11]) ns[7] = !was_locked;
                end
                ns[4] = 1'b1;
            end
            if (evt_button) ns[0] = 1'b1;
            if (evt_hot_add && !was_locked)    begin ns[6] = 1'b1; ns[3] = 1'b1; end
            if (evt_hot_remove && !was_locked) begin ns[6] = 1'b0; ns[3] = 1'b1; end
            if (evt_boot_present) ns[6] = 1'b1;
            m_sts = ns;
        end
        m_valid = 1;
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (m_valid) begin
            logic c;
            c = m_cond(m_ctl, m_sts);
            if (rd_sel) chk("R3 model rd_data", rd_data, {m_sts, m_ctl});
            else        chk("R13 model rd_data", rd_data, CAP_EXP);
            chk("R11 model irq_level", {31'd0, irq_level}, {31'd0, !msi_en && c});
            chk("R10 model msg_pulse", {31'd0, msg_pulse}, {31'd0, msi_en && (c != m_prevc)});
            chk("R7 model plug_busy", {31'd0, plug_busy},
                {31'd0, m_sts[7] && (evt_hot_add || evt_hot_remove)});
            if (msg_pulse) chk("R10 model msg_vector", {27'd0, msg_vector}, {27'd0, msg_num});
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick;
        @(posedge clk);
        #1;
        wr_en = 0; wr_be = 0; wr_data = 0;
        evt_button = 0; evt_hot_add = 0; evt_hot_remove = 0; evt_boot_present = 0;
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        wr_en = 1; wr_sel = 1; wr_be = be; wr_data = d;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1;
        tick(); tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 reset ctl/sts", rd_data, 32'h0000_03C0);
        chk("R1 reset level", {31'd0, irq_level}, 32'd0);
        rd_sel = 0; #1;
        chk("R13 capability word", rd_data, CAP_EXP);
        rd_sel = 1;

        // write to capability dword has no effect
        wr_en = 1; wr_sel = 0; wr_be = 4'hF; wr_data = 32'hFFFF_FFFF; tick();
        rd_sel = 0; #1;
        chk("R13 capability after write", rd_data, CAP_EXP);
        rd_sel = 1; #1;
        chk("R13 cap write leaves regs", rd_data, 32'h0000_03C0);

        // R2/R3 command write
        wr(4'b0011, 32'h0000_07FF);
        chk("R3 writable control bits", rd_data, 32'h0010_03F9);
        chk("R11 R9 level from cc", {31'd0, irq_level}, 32'd1);

        // R5 clear cc; R2 status-only write sets no cc
        wr(4'b0100, 32'h0010_0000);
        chk("R5 R2 cc cleared, no new cc", rd_data, 32'h0000_03F9);
        chk("R9 level drops", {31'd0, irq_level}, 32'd0);

        // R6 boot present
        evt_boot_present = 1; tick();
        chk("R6 boot present no pdc", rd_data, 32'h0040_03F9);

        // R5 presence/lock not clearable
        wr(4'b1100, 32'h00C0_0000);
        chk("R5 pres/lock ignore w1c", rd_data, 32'h0040_03F9);

        // R4 lock toggle, R3 bit 11 reads 0
        wr(4'b0010, 32'h0000_0800);
        chk("R4 R3 lock set", rd_data, 32'h00D0_00F9);

        // R7 refused while locked
        evt_hot_add = 1; #1;
        chk("R7 busy while locked", {31'd0, plug_busy}, 32'd1);
        tick();
        chk("R7 state unchanged", rd_data, 32'h00D0_00F9);

        // unlock, clear cc
        wr(4'b0010, 32'h0000_0800);
        chk("R4 lock cleared", rd_data, 32'h0050_00F9);
        wr(4'b0100, 32'h0010_0000);

        // R6 hot remove / hot add
        evt_hot_remove = 1; tick();
        chk("R6 hot remove", rd_data, 32'h0008_00F9);
        chk("R11 level on pdc", {31'd0, irq_level}, 32'd1);
        evt_hot_add = 1; tick();
        chk("R6 hot add", rd_data, 32'h0048_00F9);
        wr(4'b0100, 32'h0008_0000);

        // R10 message mode
        msi_en = 1; msg_num = 5'd19;
        evt_button = 1; tick();
        chk("R8 button status", rd_data, 32'h0041_00F9);
        chk("R10 pulse on rise", {31'd0, msg_pulse}, 32'd1);
        chk("R10 vector", {27'd0, msg_vector}, 32'd19);
        chk("R11 no level in msi", {31'd0, irq_level}, 32'd0);
        tick();
        chk("R10 pulse one cycle", {31'd0, msg_pulse}, 32'd0);
        evt_button = 1; tick();
        chk("R10 no pulse on repeat set", {31'd0, msg_pulse}, 32'd0);

        // R12 event beats clear
        evt_button = 1; wr(4'b0100, 32'h0001_0000);
        chk("R12 event wins", rd_data, 32'h0041_00F9);
        wr(4'b0100, 32'h0001_0000);
        chk("R10 pulse on fall", {31'd0, msg_pulse}, 32'd1);

        // R9 disable then re-enable with pending event
        wr(4'b0001, 32'h0000_00D9);
        chk("R9 masked by hpi off", {31'd0, msg_pulse}, 32'd0);
        wr(4'b0001, 32'h0000_00F9);
        chk("R9 pending on enable", {31'd0, msg_pulse}, 32'd1);

        // R1 reset while locked
        wr(4'b0010, 32'h0000_0800);
        rst = 1; tick(); rst = 0; tick();
        chk("R1 reset clears lock", rd_data, 32'h0000_03C0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule